// File: doc/BRIEF.md
# Byte-Parity RAM Guard with Fault-to-Break Routing

This block wraps a synchronous RAM that is 32 data bits wide. Each stored word carries one extra bit per byte lane: the even-parity bit of that byte, so a word is 36 bits in all. A write computes the parity bits from the incoming bytes and stores them with the data. Only the byte lanes selected by the byte enables are updated, data and parity alike. A read returns the data one cycle after the request. When checking is enabled, the stored parity of every lane is recomputed and compared in that same response cycle. A mismatch in any lane raises an error indication next to the valid data. The data is returned whether or not a lane fails.

A failing read sets a sticky error flag, which software clears by writing one to it, and produces a one-cycle non-maskable interrupt pulse. A small control word also holds four routing enables. Each enable connects one fault source to a timer break output: the flash ECC error, the voltage detector event, the stored parity error flag and the core hard fault. A routing enable can be set by software but not cleared. It stays set until reset. For test, a per-lane inversion input can store a deliberately wrong parity bit on write.

Top module: `parity_ram_guard`

## Requirements
- R1: A read request (req_valid=1, req_write=0) produces rsp_valid=1 in the next cycle only, with rsp_rdata holding the bytes last written to that address. Write requests produce no response.
- R2: On a write, only the byte lanes whose req_be bit is 1 are updated (bit i selects rsp_rdata/req_wdata bits 8i+7..8i). The other lanes keep their earlier data.
- R3: Each written lane stores the even-parity bit of its byte XOR req_par_flip[i]. A lane written with a clear flip bit reads back with rsp_perr=0.
- R4: With checking enabled, a read in which any lane's stored parity does not match its data drives rsp_perr=1 in the same cycle as rsp_valid. The data is still returned unchanged.
- R5: Checking is off after reset and while ctl_wdata bit 0 was last written as 0. With checking off, rsp_perr stays 0 for every read. chk_en_o shows the bit.
- R6: err_flag_o becomes 1 in the cycle after a response with rsp_perr=1 and holds. A control write with bit 1 set clears it, but a parity error in the same cycle wins.
- R7: nmi_o is 1 for exactly the one cycle after each response with rsp_perr=1, and 0 otherwise.
- R8: Control write bits 5..2 set route_en_o bits 3..0. A bit written as 1 stays 1 until reset, and a 0 written to it has no effect.
- R9: brk_o is 1 when any routed source is active. The source order is bit 0 flash_ecc_evt, bit 1 volt_det_evt, bit 2 err_flag_o, bit 3 core_hardfault. An unrouted source has no effect on brk_o.
- R10: During and after reset, rsp_valid, rsp_perr, chk_en_o, err_flag_o, nmi_o, route_en_o and brk_o are 0.
- R11: req_par_flip bits for lanes not written have no effect. A partial write leaves the parity of the other lanes as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane write enables |
| req_par_flip | input | DATA_W/8 | Invert stored parity of written lanes (test) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_perr | output | 1 | Parity error on this response |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Bit0 check enable, bit1 clear flag, bits5..2 routing set |
| flash_ecc_evt | input | 1 | Flash ECC fault source |
| volt_det_evt | input | 1 | Voltage detector fault source |
| core_hardfault | input | 1 | Core hard fault source |
| chk_en_o | output | 1 | Parity checking enabled |
| err_flag_o | output | 1 | Sticky parity error flag |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| route_en_o | output | 4 | Locked routing enables |
| brk_o | output | 1 | Timer break request |

## Verification
A wrong parity bit in a lane's storage shows up only when that address is read with checking on. It then appears at rsp_perr in the response cycle, and as nmi_o and err_flag_o one cycle later. Faults in the flag or routing registers appear at brk_o at once, because brk_o is combinational over them. A routing bit that was lost or cleared therefore changes brk_o as soon as its source becomes active. A lane updated without its enable corrupts rsp_rdata on the next read of that address.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int SRC_N     = 4;
  localparam int CTL_CHK   = 0;
  localparam int CTL_CLR   = 1;
  localparam int CTL_RT_LO = 2;
  localparam int CTL_W     = CTL_RT_LO + SRC_N;

  // even parity bit: makes the 9-bit group carry an even count of ones
  function automatic logic even_bit(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic logic par_mismatch(input logic [7:0] b, input logic p);
    return even_bit(b) ^ p;
  endfunction
endpackage

// File: rtl/pgw_lane_mem.sv
module pgw_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/pgw_par_check.sv
module pgw_par_check import pgw_pkg::*; #(
  parameter int LANES = 4
) (
  input  logic               rsp_valid,
  input  logic               chk_en,
  input  logic [LANES*8-1:0] data,
  input  logic [LANES-1:0]   par,
  output logic [LANES-1:0]   lane_bad,
  output logic               err
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = par_mismatch(data[g*8 +: 8], par[g]);
  end

  assign err = rsp_valid & chk_en & (|lane_bad);
endmodule

// File: rtl/pgw_ctl.sv
module pgw_ctl import pgw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             err_event,
  input  logic             flash_ecc_evt,
  input  logic             volt_det_evt,
  input  logic             core_hardfault,
  output logic             chk_en,
  output logic             err_flag,
  output logic             nmi,
  output logic [SRC_N-1:0] route_en,
  output logic             brk
);
  logic [SRC_N-1:0] src_vec;
  logic [SRC_N-1:0] route_set;
  logic             clr_req;

  assign clr_req   = ctl_wr & ctl_wdata[CTL_CLR];
  assign route_set = ctl_wr ? ctl_wdata[CTL_RT_LO +: SRC_N] : '0;
  assign src_vec   = {core_hardfault, err_flag, volt_det_evt, flash_ecc_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en   <= 1'b0;
      err_flag <= 1'b0;
      nmi      <= 1'b0;
      route_en <= '0;
    end else begin
      if (ctl_wr) chk_en <= ctl_wdata[CTL_CHK];
      // a new error outranks a clear written in the same cycle
      if (err_event)    err_flag <= 1'b1;
      else if (clr_req) err_flag <= 1'b0;
      nmi      <= err_event;
      route_en <= route_en | route_set;
    end
  end

  assign brk = |(route_en & src_vec);
endmodule

// File: rtl/parity_ram_guard.sv
module parity_ram_guard import pgw_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [DATA_W/8-1:0]   req_par_flip,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_perr,
  input  logic                  ctl_wr,
  input  logic [CTL_W-1:0]      ctl_wdata,
  input  logic                  flash_ecc_evt,
  input  logic                  volt_det_evt,
  input  logic                  core_hardfault,
  output logic                  chk_en_o,
  output logic                  err_flag_o,
  output logic                  nmi_o,
  output logic [SRC_N-1:0]      route_en_o,
  output logic                  brk_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = 9;

  // named internal events for the bound checker
  logic             rd_fire;
  logic             wr_fire;
  logic             ctl_clr_req;
  logic [LANES-1:0] lane_par;
  logic [LANES-1:0] lane_bad;

  assign rd_fire     = req_valid & ~req_write;
  assign wr_fire     = req_valid &  req_write;
  assign ctl_clr_req = ctl_wdata[CTL_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rd_fire;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] w_word;
    logic [LANE_W-1:0] r_word;

    assign w_word = {even_bit(req_wdata[g*8 +: 8]) ^ req_par_flip[g],
                     req_wdata[g*8 +: 8]};

    pgw_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .wr_en (wr_fire & req_be[g]),
      .rd_en (rd_fire),
      .addr  (req_addr),
      .wdata (w_word),
      .rdata (r_word)
    );

    assign rsp_rdata[g*8 +: 8] = r_word[7:0];
    assign lane_par[g]         = r_word[8];
  end

  pgw_par_check #(.LANES(LANES)) u_check (
    .rsp_valid (rsp_valid),
    .chk_en    (chk_en_o),
    .data      (rsp_rdata),
    .par       (lane_par),
    .lane_bad  (lane_bad),
    .err       (rsp_perr)
  );

  pgw_ctl u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_wr         (ctl_wr),
    .ctl_wdata      (ctl_wdata),
    .err_event      (rsp_perr),
    .flash_ecc_evt  (flash_ecc_evt),
    .volt_det_evt   (volt_det_evt),
    .core_hardfault (core_hardfault),
    .chk_en         (chk_en_o),
    .err_flag       (err_flag_o),
    .nmi            (nmi_o),
    .route_en       (route_en_o),
    .brk            (brk_o)
  );
endmodule

// File: rtl/parity_ram_guard_chk.sv
module parity_ram_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_fire,
  input logic       rsp_valid,
  input logic       rsp_perr,
  input logic       chk_en,
  input logic       err_flag,
  input logic       nmi,
  input logic [3:0] route_en,
  input logic       brk,
  input logic       ctl_wr,
  input logic       ctl_clr
);
  a_r1_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
  a_r1_no_rsp_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid);
  a_r4_err_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |-> rsp_valid);
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> !rsp_perr);
  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |=> err_flag);
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(ctl_wr && ctl_clr)) |=> err_flag);
  a_r7_nmi_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |=> nmi);
  a_r7_nmi_only_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_perr |=> !nmi);
  a_r8_route_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((route_en & $past(route_en)) == $past(route_en)));
  a_r9_brk_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (route_en != 4'b0000));
endmodule

bind parity_ram_guard parity_ram_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_fire   (rd_fire),
  .rsp_valid (rsp_valid),
  .rsp_perr  (rsp_perr),
  .chk_en    (chk_en_o),
  .err_flag  (err_flag_o),
  .nmi       (nmi_o),
  .route_en  (route_en_o),
  .brk       (brk_o),
  .ctl_wr    (ctl_wr),
  .ctl_clr   (ctl_clr_req)
);

// File: tb/parity_ram_guard_tb.sv
`timescale 1ns/1ps
module parity_ram_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0, req_par_flip = '0;
  logic        rsp_valid, rsp_perr;
  logic [31:0] rsp_rdata;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic        flash_ecc_evt = 1'b0, volt_det_evt = 1'b0, core_hardfault = 1'b0;
  logic        chk_en_o, err_flag_o, nmi_o, brk_o;
  logic [3:0]  route_en_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  parity_ram_guard u_dut (.*);

  // bench model: bytes plus stored parity bits
  logic [7:0] mdat [256][4];
  logic       mpar [256][4];

  // {addr, data, be, flip}
  localparam logic [47:0] VEC [8] = '{
    48'h03_A5A50F0F_F_0,
    48'h10_12345678_F_1,
    48'h10_FFFFFF00_1_0,
    48'h20_DEADBEEF_F_0,
    48'h20_00000000_4_8,
    48'h21_80000001_F_4,
    48'hFF_FFFFFFFF_F_0,
    48'h00_00000000_F_F
  };

  function automatic logic ones_odd(input logic [7:0] b);
    int n = 0;
    for (int k = 0; k < 8; k++) n += int'(b[k]);
    return (n % 2) == 1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] be, input logic [3:0] fl);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    req_be = be; req_par_flip = fl;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    for (int l = 0; l < 4; l++) if (be[l]) begin
      mdat[a][l] = d[l*8 +: 8];
      mpar[a][l] = ones_odd(d[l*8 +: 8]) ^ fl[l];
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic v,
                         output logic [31:0] d, output logic pe);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; d = rsp_rdata; pe = rsp_perr;
  endtask

  task automatic ctl_write(input logic [5:0] w);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  function automatic logic [31:0] model_data(input logic [7:0] a);
    return {mdat[a][3], mdat[a][2], mdat[a][1], mdat[a][0]};
  endfunction

  function automatic logic model_err(input logic [7:0] a, input logic chk);
    logic e = 0;
    for (int l = 0; l < 4; l++) e |= (mpar[a][l] != ones_odd(mdat[a][l]));
    return chk & e;
  endfunction

  initial begin
    logic v, pe;
    logic [31:0] d;

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 err_flag", err_flag_o, 0);
    check("R10 nmi", nmi_o, 0);
    check("R10 route", route_en_o, 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 chk_en", chk_en_o, 0);
    check("R10 brk", brk_o, 0);
    check("R10 rsp_perr", rsp_perr, 0);

    // R5 checking off after reset: a bad-parity word reads clean
    do_write(8'h40, 32'h0F0F0F0F, 4'hF, 4'h3);
    check("R1 no response to write", rsp_valid, 0);
    do_read(8'h40, v, d, pe);
    check("R5 off after reset", pe, 0);
    check("R1 data with check off", d, 32'h0F0F0F0F);

    ctl_write(6'b000001);
    check("R5 chk_en set", chk_en_o, 1);

    // vector table: write then read back
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a;
      a = VEC[i][47:40];
      do_write(a, VEC[i][39:8], VEC[i][7:4], VEC[i][3:0]);
      do_read(a, v, d, pe);
      check($sformatf("R1 valid vec%0d", i), v, 1);
      check($sformatf("R1 R2 R11 data vec%0d", i), d, model_data(a));
      check($sformatf("R3 R4 R11 perr vec%0d", i), pe, model_err(a, 1'b1));
    end
    @(negedge clk);
    check("R1 single response", rsp_valid, 0);
    check("R6 flag after errors", err_flag_o, 1);

    // R6 clear by writing one
    ctl_write(6'b000011);
    check("R6 cleared", err_flag_o, 0);
    check("R5 chk kept", chk_en_o, 1);

    // R7 nmi one-cycle pulse, R6 sticky
    do_read(8'h21, v, d, pe);
    check("R4 perr lane2", pe, 1);
    check("R4 data kept", d, 32'h80000001);
    check("R6 not yet", err_flag_o, 0);
    @(negedge clk);
    check("R7 nmi high", nmi_o, 1);
    check("R6 flag set", err_flag_o, 1);
    @(negedge clk);
    check("R7 nmi one cycle", nmi_o, 0);
    check("R6 sticky", err_flag_o, 1);

    // R6 error wins over same-cycle clear
    ctl_write(6'b000011);
    check("R6 clear before race", err_flag_o, 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h21;
    @(negedge clk);
    req_valid = 0; ctl_wr = 1; ctl_wdata = 6'b000011;
    check("R4 race perr", rsp_perr, 1);
    @(negedge clk);
    ctl_wr = 0;
    check("R6 set wins over clear", err_flag_o, 1);

    // R5 checking turned off: clear flag and disable
    ctl_write(6'b000010);
    check("R5 chk off", chk_en_o, 0);
    do_read(8'h21, v, d, pe);
    check("R5 no perr when off", pe, 0);
    @(negedge clk);
    check("R7 no nmi when off", nmi_o, 0);
    check("R6 flag stays clear", err_flag_o, 0);

    // R8 R9 routing
    check("R9 brk idle", brk_o, 0);
    ctl_write(6'b000100);
    check("R8 route ecc", route_en_o, 4'b0001);
    flash_ecc_evt = 1; #1;
    check("R9 ecc routed", brk_o, 1);
    flash_ecc_evt = 0; volt_det_evt = 1; #1;
    check("R9 volt unrouted", brk_o, 0);
    volt_det_evt = 0;
    ctl_write(6'b000000);
    check("R8 zero ignored", route_en_o, 4'b0001);
    ctl_write(6'b111000);
    check("R8 accumulate", route_en_o, 4'b1111);
    core_hardfault = 1; #1;
    check("R9 hardfault routed", brk_o, 1);
    core_hardfault = 0; #1;
    check("R9 quiet", brk_o, 0);
    ctl_write(6'b000001);
    check("R8 still locked", route_en_o, 4'b1111);
    do_read(8'h10, v, d, pe);
    check("R3 rewritten lane clean", pe, 0);
    do_read(8'h00, v, d, pe);
    check("R4 all lanes bad", pe, 1);
    @(negedge clk);
    check("R9 parity routed", brk_o, 1);

    // R10 reset clears locks
    rst_n = 0;
    @(negedge clk);
    check("R10 route cleared", route_en_o, 0);
    check("R10 flag cleared", err_flag_o, 0);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule